// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-lane SPI master driven by a small 16-bit register interface. It has three registers: data, control and status. Software fills the control register with the enable, word size, clock mode, interrupt enables and a clock divider. A write to the data register then starts one word of 8 or 16 bits on the serial clock and data-out lines. The same word time samples the data-in line. The received word is read back from the same data location.

The clock generator divides the system clock by an integer. Each word latches its configuration when it starts, so control writes made during a word change nothing until the next one. Clearing the enable bit aborts a word at once. One registered, level-sensitive interrupt line reports a receive-full event, an idle transmitter, or both. Each source has its own enable.

Top module: `spi_master_mm`

## Requirements
- R1: After reset the control register reads 0x0000, the status register reads 0x0000, `spi_sclk` is 0 and `irq` is 0.
- R2: Registers sit at byte offsets 0x0 (data), 0x2 (control) and 0x4 (status). A read presents its value on `bus_rdata` in the cycle after `bus_rd`. The control register reads back exactly the last value written.
- R3: A data write starts a word only when control bit 0 (enable) is 1 and no word is in progress. With enable at 0, a data write produces no `spi_sclk` edge.
- R4: Control bit 2 selects the word size: 0 gives 8 bits and 1 gives 16 bits. Words are sent and received MSB first. An 8-bit word goes out from data bits 7:0, and its received value reads back in bits 7:0 with bits 15:8 at zero. A word makes exactly 2×size `spi_sclk` edges.
- R5: Control bit 7 is the idle level of `spi_sclk`. Control bit 8 selects the phase. At 0, data is sampled on the first (leading) edge of each bit and changes on the trailing edge. At 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: Control bits 15:9 hold N. Each `spi_sclk` half period lasts max(N,1)+1 system clocks, so a value of 0 behaves like 1.
- R7: Status bit 0 (busy) is 1 while a word is in progress. Status bit 1 (receive full) is set when a word completes and cleared by a read of the data register.
- R8: A data write while busy is ignored. The word in progress finishes unchanged and no second word starts.
- R9: Clearing control bit 0 during a word ends it. Busy returns to 0 without setting receive full, and `spi_sclk` returns to its idle level.
- R10: `irq` is registered. Its value is (bit 5 AND receive full) OR (bit 6 AND NOT busy AND bit 0), taken from the previous cycle.
- R11: Word size, clock mode and divider are captured when a word starts. Control writes during a word change neither its edge count nor its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the bus never raises `bus_wr` and `bus_rd` in the same cycle. They also assume `spi_miso` holds steady around each sampling edge, and that reset is held for several clocks before use. The bench drives strobes one at a time, away from the clock edge. Its slave model moves `spi_miso` only on the edges where the master shifts, never on the edges where it samples. It also arms itself only after a control write has settled, so a change of idle level is never counted as a transfer edge.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 7;
  localparam int HALF_W = DIV_W + 1;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'h0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'h2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'h4;

  localparam int BIT_EN      = 0;
  localparam int BIT_WIDE    = 2;
  localparam int BIT_IE_RX   = 5;
  localparam int BIT_IE_IDLE = 6;
  localparam int BIT_CPOL    = 7;
  localparam int BIT_CPHA    = 8;
  localparam int BIT_DIV_LO  = 9;

  typedef struct packed {
    logic              wide;
    logic              cpol;
    logic              cpha;
    logic [HALF_W-1:0] half;
  } word_cfg_t;
endpackage

// File: rtl/spi_mm_regs.sv
module spi_mm_regs
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [REG_W-1:0]  rx_word,
  output logic [REG_W-1:0]  ctl,
  output logic              rxfull,
  output logic              start,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic [REG_W-1:0] rx_hold;
  logic             data_wr, data_rd, ctl_wr;

  assign data_wr = bus_wr && (bus_addr == OFS_DATA);
  assign data_rd = bus_rd && (bus_addr == OFS_DATA);
  assign ctl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign start   = data_wr && ctl[BIT_EN] && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      rx_hold <= '0;
      rxfull  <= 1'b0;
      rdata   <= '0;
      irq     <= 1'b0;
    end else begin
      if (ctl_wr) ctl <= bus_wdata;
      if (done) begin
        rx_hold <= rx_word;
        rxfull  <= 1'b1;
      end else if (data_rd) begin
        rxfull  <= 1'b0;
      end
      if (bus_rd) begin
        case (bus_addr)
          OFS_DATA: rdata <= rx_hold;
          OFS_CTRL: rdata <= ctl;
          OFS_STAT: rdata <= {{(REG_W-2){1'b0}}, rxfull, busy};
          default:  rdata <= '0;
        endcase
      end
      irq <= (ctl[BIT_IE_RX] && rxfull) ||
             (ctl[BIT_IE_IDLE] && !busy && ctl[BIT_EN]);
    end
  end
endmodule

// File: rtl/spi_mm_clkgen.sv
module spi_mm_clkgen #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign tick = run && (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_mm_shifter.sv
module spi_mm_shifter
  import spi_mm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             enable,
  input  word_cfg_t        cfg_in,
  input  logic [REG_W-1:0] tx_word,
  input  logic             tick,
  input  logic             miso,
  output word_cfg_t        cfg,
  output logic             busy,
  output logic             done,
  output logic [REG_W-1:0] rx_word,
  output logic             sclk,
  output logic             mosi
);
  localparam int EDGE_W = $clog2(2 * REG_W);

  logic [REG_W-1:0]  tx_sh, rx_sh;
  logic [EDGE_W-1:0] edge_cnt, last_edge;
  logic              leading, sample_now, shift_now;

  assign last_edge  = cfg.wide ? EDGE_W'(2 * REG_W - 1) : EDGE_W'(2 * BYTE_W - 1);
  assign leading    = !edge_cnt[0];
  assign sample_now = cfg.cpha ? !leading : leading;
  assign shift_now  = cfg.cpha ? (leading && edge_cnt != '0) : !leading;
  assign mosi       = tx_sh[REG_W-1];
  assign rx_word    = cfg.wide ? rx_sh : {{(REG_W-BYTE_W){1'b0}}, rx_sh[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_cnt <= '0;
      sclk     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cfg_in.cpol;
        if (start) begin
          busy     <= 1'b1;
          cfg      <= cfg_in;
          tx_sh    <= cfg_in.wide ? tx_word
                                  : {tx_word[BYTE_W-1:0], {(REG_W-BYTE_W){1'b0}}};
          rx_sh    <= '0;
          edge_cnt <= '0;
        end
      end else if (!enable) begin
        busy <= 1'b0;
      end else if (tick) begin
        sclk     <= ~sclk;
        edge_cnt <= edge_cnt + 1'b1;
        if (sample_now) rx_sh <= {rx_sh[REG_W-2:0], miso};
        if (shift_now)  tx_sh <= {tx_sh[REG_W-2:0], 1'b0};
        if (edge_cnt == last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_master_mm.sv
module spi_master_mm
  import spi_mm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);
  logic [REG_W-1:0] ctl, rx_word;
  logic             rxfull, start, busy, done, tick;
  logic             ctl_en, ctl_cpol, ie_rx, ie_idle, data_wr, data_rd;
  logic [DIV_W-1:0] div_n;
  word_cfg_t        cfg_next, cfg_run;

  assign ctl_en   = ctl[BIT_EN];
  assign ctl_cpol = ctl[BIT_CPOL];
  assign ie_rx    = ctl[BIT_IE_RX];
  assign ie_idle  = ctl[BIT_IE_IDLE];
  assign div_n    = ctl[BIT_DIV_LO +: DIV_W];
  assign data_wr  = bus_wr && (bus_addr == OFS_DATA);
  assign data_rd  = bus_rd && (bus_addr == OFS_DATA);

  always_comb begin
    cfg_next.wide = ctl[BIT_WIDE];
    cfg_next.cpol = ctl[BIT_CPOL];
    cfg_next.cpha = ctl[BIT_CPHA];
    cfg_next.half = (div_n == '0) ? HALF_W'(2) : HALF_W'({1'b0, div_n}) + 1'b1;
  end

  spi_mm_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done(done),
    .rx_word(rx_word), .ctl(ctl), .rxfull(rxfull), .start(start),
    .rdata(bus_rdata), .irq(irq)
  );

  spi_mm_clkgen #(.HALF_W(HALF_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(busy), .half(cfg_run.half), .tick(tick)
  );

  spi_mm_shifter u_shift (
    .clk(clk), .rst(rst), .start(start), .enable(ctl_en), .cfg_in(cfg_next),
    .tx_word(bus_wdata), .tick(tick), .miso(spi_miso), .cfg(cfg_run),
    .busy(busy), .done(done), .rx_word(rx_word), .sclk(spi_sclk),
    .mosi(spi_mosi)
  );
endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic ctl_en,
  input logic ctl_cpol,
  input logic ie_rx,
  input logic ie_idle,
  input logic rxfull,
  input logic data_wr,
  input logic data_rd,
  input logic sclk,
  input logic irq
);
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !busy); // R9

  AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (sclk == $past(ctl_cpol))); // R5

  AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(data_wr && ctl_en)); // R3

  AST_RXFULL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !done) |=> !rxfull); // R7

  AST_DONE_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
    done |=> rxfull); // R7

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == $past((ie_rx && rxfull) || (ie_idle && !busy && ctl_en))); // R10
endmodule

bind spi_master_mm spi_mm_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ctl_en(ctl_en),
  .ctl_cpol(ctl_cpol), .ie_rx(ie_rx), .ie_idle(ie_idle), .rxfull(rxfull),
  .data_wr(data_wr), .data_rd(data_rd), .sclk(spi_sclk), .irq(irq)
);

// File: tb/spi_master_mm_tb.sv
module spi_master_mm_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso, irq;

  int n_checks = 0, n_fails = 0;
  int cyc = 0;
  bit finished = 0;

  // slave model state: tasks write s_gen/s_pat/s_cpol/s_cpha/s_on only
  int          s_gen = 0;
  logic [15:0] s_pat = '0;
  bit          s_cpol = 0, s_cpha = 0, s_on = 0;
  int          s_seen = 0, s_idx = 0, s_edges = 0, s_first = 0, s_last = 0;
  logic [15:0] s_rx = '0;

  spi_master_mm u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  int eff_idx;
  assign eff_idx  = (s_seen == s_gen) ? s_idx : 0;
  assign spi_miso = (eff_idx > 15) ? 1'b0 : s_pat[15 - eff_idx];

  always @(spi_sclk) begin
    bit lead;
    if (s_seen != s_gen) begin
      s_seen = s_gen; s_idx = 0; s_edges = 0; s_rx = '0;
    end
    if (s_on) begin
      s_edges = s_edges + 1;
      if (s_edges == 1) s_first = cyc;
      s_last = cyc;
      lead = (spi_sclk != s_cpol);
      if (!s_cpha) begin
        if (lead) s_rx = {s_rx[14:0], spi_mosi};
        else      s_idx = s_idx + 1;
      end else begin
        if (lead) begin
          if (s_edges != 1) s_idx = s_idx + 1;
        end else s_rx = {s_rx[14:0], spi_mosi};
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit en, bit wide, bit ierx, bit ieid,
                                      bit cpol, bit cpha, int n);
    logic [6:0] nn = n[6:0];
    return {nn, cpha, cpol, ieid, ierx, 2'b00, wide, 1'b0, en};
  endfunction

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(string req);
    logic [15:0] st;
    int k = 0;
    do begin rd(3'h4, st); k++; end while (st[0] && k < 3000);
    if (st[0]) check(req, 1, 0);
  endtask

  task automatic arm(bit cpol, bit cpha, logic [15:0] pat, bit wide);
    s_cpol = cpol; s_cpha = cpha;
    s_pat = wide ? pat : {pat[7:0], 8'h00};
    s_on = 1; s_gen = s_gen + 1;
  endtask

  // one full word: configure, transfer, compare both directions and timing
  task automatic run_word(string req, int mode, bit wide, int n,
                          logic [15:0] tx, logic [15:0] pat);
    logic [15:0] d;
    int bits = wide ? 16 : 8;
    int half = ((n == 0) ? 1 : n) + 1;
    wr(3'h2, mk(1, wide, 0, 0, mode[1], mode[0], n));
    idle(3);
    arm(mode[1], mode[0], pat, wide);
    wr(3'h0, tx);
    wait_idle(req);
    rd(3'h0, d);
    check({req, " rx word"}, d, wide ? pat : {8'h00, pat[7:0]});
    check({req, " slave got"}, wide ? s_rx : {8'h00, s_rx[7:0]},
          wide ? tx : {8'h00, tx[7:0]});
    check({req, " edge count"}, s_edges, 2 * bits);
    check({req, " edge span"}, s_last - s_first, (2 * bits - 1) * half);
    check({req, " sclk idle"}, spi_sclk, mode[1]);
    s_on = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 sclk", spi_sclk, 0);
    check("R1 irq", irq, 0);
    rd(3'h2, d); check("R1 ctl", d, 0);
    rd(3'h4, d); check("R1 status", d, 0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(3'h2, 16'hFE80); rd(3'h2, d); check("R2 ctl readback", d, 16'hFE80);
    wr(3'h2, 16'h0000); idle(2); rd(3'h2, d); check("R2 ctl clear", d, 0);
  endtask

  task automatic t_disabled;
    logic [15:0] d;
    wr(3'h2, mk(0, 0, 0, 0, 0, 0, 1));
    idle(3); arm(0, 0, 16'h0055, 0);
    wr(3'h0, 16'h00AA); idle(60);
    check("R3 no edges when disabled", s_edges, 0);
    rd(3'h4, d); check("R3 status idle", d, 0);
    s_on = 0;
  endtask

  task automatic t_status;
    logic [15:0] d;
    wr(3'h2, mk(1, 0, 0, 0, 0, 0, 4));
    idle(3); arm(0, 0, 16'h0081, 0);
    wr(3'h0, 16'h0018);
    rd(3'h4, d); check("R7 busy during word", d, 16'h0001);
    wait_idle("R7");
    rd(3'h4, d); check("R7 full after word", d, 16'h0002);
    rd(3'h0, d); check("R7 data", d, 16'h0081);
    rd(3'h4, d); check("R7 full cleared by read", d, 16'h0000);
    s_on = 0;
  endtask

  task automatic t_busy_write;
    logic [15:0] d;
    wr(3'h2, mk(1, 0, 0, 0, 0, 0, 3));
    idle(3); arm(0, 0, 16'h0011, 0);
    wr(3'h0, 16'h005A);
    idle(4);
    wr(3'h0, 16'h00C3);
    wait_idle("R8");
    idle(40);
    check("R8 first word intact", s_rx[7:0], 8'h5A);
    check("R8 no second word", s_edges, 16);
    rd(3'h0, d);
    s_on = 0;
  endtask

  task automatic t_abort;
    logic [15:0] d;
    wr(3'h2, mk(1, 1, 0, 0, 1, 0, 10));
    idle(3); arm(1, 0, 16'hFFFF, 1);
    wr(3'h0, 16'h1234);
    idle(30);
    wr(3'h2, mk(0, 1, 0, 0, 1, 0, 10));
    idle(3);
    rd(3'h4, d); check("R9 abort status", d, 0);
    check("R9 sclk idle after abort", spi_sclk, 1);
    s_on = 0;
  endtask

  task automatic t_irq;
    logic [15:0] d;
    wr(3'h2, mk(1, 0, 0, 1, 0, 0, 1)); idle(2);
    check("R10 idle irq", irq, 1);
    wr(3'h2, mk(0, 0, 0, 1, 0, 0, 1)); idle(2);
    check("R10 idle irq needs enable", irq, 0);
    wr(3'h2, mk(1, 0, 1, 0, 0, 0, 1)); idle(2);
    check("R10 rx irq quiet", irq, 0);
    arm(0, 0, 16'h0042, 0);
    wr(3'h0, 16'h0024);
    wait_idle("R10"); idle(2);
    check("R10 rx irq", irq, 1);
    rd(3'h0, d); idle(2);
    check("R10 rx irq drops", irq, 0);
    s_on = 0;
  endtask

  task automatic t_capture;
    logic [15:0] d;
    wr(3'h2, mk(1, 0, 0, 0, 0, 0, 1));
    idle(3); arm(0, 0, 16'h00E7, 0);
    wr(3'h0, 16'h0096);
    wr(3'h2, mk(1, 1, 0, 0, 0, 0, 6));
    wait_idle("R11");
    rd(3'h0, d);
    check("R11 edges of running word", s_edges, 16);
    check("R11 span of running word", s_last - s_first, 30);
    check("R11 rx of running word", d, 16'h00E7);
    s_on = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_reset();
    t_regs();
    t_disabled();
    run_word("R4 R5 mode0 8b N0 R6", 0, 0, 0, 16'h00A5, 16'h003C);
    run_word("R5 mode1 8b", 1, 0, 2, 16'h00C9, 16'h0071);
    run_word("R5 mode2 8b", 2, 0, 2, 16'h0033, 16'h00D4);
    run_word("R5 mode3 8b", 3, 0, 2, 16'h008E, 16'h0019);
    run_word("R4 16b mode0", 0, 1, 1, 16'h1234, 16'hBEEF);
    run_word("R4 16b mode3", 3, 1, 3, 16'h8001, 16'h7FFE);
    run_word("R6 divider 4", 1, 0, 4, 16'h0055, 16'h00AA);
    t_status();
    t_busy_write();
    t_abort();
    t_irq();
    t_capture();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule